// File: doc/BRIEF.md
# System Control Flag and Enable Registers

This block is a small bank of four byte-wide control registers sitting at the bottom of a peripheral address space. Two registers hold interrupt enables: one for the watchdog, oscillator fault, non-maskable pin interrupt and flash access violation, and one for the receive and transmit sides of a set of serial channels. The other two registers hold the matching flags. These include the flags that tell software why the device last came out of reset: power-on, reset pin, or watchdog.

Two reset inputs are provided. The power-on reset clears everything. The power-up clear is a lighter reset that also follows any reset-pin or watchdog reset. Each bit belongs to exactly one of the two reset domains and has its own reset value. The cause flags survive a power-up clear, so software can read them after the device restarts.

Hardware events arrive as single-cycle pulses and set flags. Software reads and writes the registers through a simple synchronous bus, and read data appears one cycle after the request. Bit positions with no function always read as 0, and writes to them are discarded. The watchdog enable only reaches the interrupt logic while the watchdog runs as an interval timer.

Top module: `sfr_bank`

## Requirements
- R1: While `por_i` is high, every register takes its power-on value: enable register 0 and enable register 1 read 00h, flag register 0 reads 06h (power-on flag bit 2 = 1, oscillator flag bit 1 = 1), and flag register 1 reads 0Ah (transmit flags at bits 1 and 3 = 1, receive flags at bits 0 and 2 = 0).
- R2: While `puc_i` is high without `por_i`, both enable registers clear to 00h, oscillator flag bit 1 goes to 1, NMI flag bit 4 goes to 0 and flag register 1 goes to 0Ah. The power-on flag (bit 2), reset-pin flag (bit 3) and watchdog flag (bit 0) keep their values.
- R3: A `pin_rst_evt_i` pulse sets the reset-pin flag (flag register 0, bit 3) and clears the watchdog flag (bit 0). If `wdt_evt_i` arrives in the same cycle, the watchdog flag is set instead.
- R4: Event pulses set their flags one cycle later. `wdt_evt_i` sets bit 0, `osc_fault_evt_i` sets bit 1 and `nmi_evt_i` sets bit 4 of flag register 0. Channel c's receive event sets bit 2c and its transmit event sets bit 2c+1 of flag register 1.
- R5: When a hardware set and a software write of 0 reach the same flag in the same cycle, the flag ends up as 1. The other bits take the written value.
- R6: Bus addresses select enable register 0 (0), enable register 1 (1), flag register 0 (2) and flag register 1 (3). The implemented bits are 33h, 0Fh, 1Fh and 0Fh in that order. Unimplemented bits read 0 and ignore writes.
- R7: A read (`bus_sel_i`=1, `bus_wr_i`=0) returns the addressed register on `bus_rdata_o` one cycle later. At all other times `bus_rdata_o` holds its value, including during writes.
- R8: `wdt_irq_en_o` is registered and equals enable register 0 bit 0 ANDed with `interval_mode_i` from the previous cycle. It is 0 whenever the watchdog is in reset mode (`interval_mode_i`=0).
- R9: Bus writes issued while `puc_i` or `por_i` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| puc_i | input | 1 | Power-up clear, synchronous, active high |
| bus_sel_i | input | 1 | Bus access request |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register select |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| wdt_evt_i | input | 1 | Watchdog overflow or key violation pulse |
| pin_rst_evt_i | input | 1 | Reset-pin reset pulse |
| osc_fault_evt_i | input | 1 | Oscillator fault pulse |
| nmi_evt_i | input | 1 | NMI pin event pulse |
| ser_rx_evt_i | input | N_CH | Per-channel receive event pulses |
| ser_tx_evt_i | input | N_CH | Per-channel transmit event pulses |
| interval_mode_i | input | 1 | 1 = watchdog runs as interval timer |
| ie1_o | output | 8 | Enable register 0 contents |
| ie2_o | output | 8 | Enable register 1 contents |
| ifg1_o | output | 8 | Flag register 0 contents |
| ifg2_o | output | 8 | Flag register 1 contents |
| wdt_irq_en_o | output | 1 | Effective watchdog interrupt enable |

## Verification
The assertions check the following on every cycle:
- the power-on state at the end of reset;
- that cause flags survive a power-up clear;
- the reset-pin effect on the reset-pin and watchdog flags;
- that an oscillator event always wins over a write;
- that unused bits of a read of register 0 are zero;
- that read data holds when no read is requested;
- that the watchdog enable is suppressed in reset mode.

Only the directed scenarios can show the exact values: each event's target bit, the per-register write masks, the transmit and receive reset values of the serial flags, and that writes during a clear are dropped.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int SFR_DW = 8;
  localparam int SFR_AW = 2;
  localparam int SFR_NREG = 4;

  localparam logic [SFR_AW-1:0] A_IE1  = 2'd0;
  localparam logic [SFR_AW-1:0] A_IE2  = 2'd1;
  localparam logic [SFR_AW-1:0] A_IFG1 = 2'd2;
  localparam logic [SFR_AW-1:0] A_IFG2 = 2'd3;

  localparam int B_WDT = 0;
  localparam int B_OSC = 1;
  localparam int B_POR = 2;
  localparam int B_RST = 3;
  localparam int B_NMI = 4;
  localparam int B_ACV = 5;

  localparam logic [SFR_DW-1:0] IE1_IMPL   = 8'h33;
  localparam logic [SFR_DW-1:0] IFG1_IMPL  = 8'h1F;
  localparam logic [SFR_DW-1:0] IFG1_PORD  = 8'h0D;
  localparam logic [SFR_DW-1:0] IFG1_RSTV  = 8'h06;

  function automatic logic [SFR_DW-1:0] ser_mask(input int nch);
    logic [SFR_DW-1:0] m;
    for (int i = 0; i < SFR_DW; i++) m[i] = (i < 2*nch);
    return m;
  endfunction

  function automatic logic [SFR_DW-1:0] ser_tx_mask(input int nch);
    logic [SFR_DW-1:0] m;
    for (int i = 0; i < SFR_DW; i++) m[i] = (i < 2*nch) && ((i % 2) == 1);
    return m;
  endfunction
endpackage

// File: rtl/sfr_bit_cell.sv
module sfr_bit_cell #(
  parameter bit IMPL    = 1'b1,
  parameter bit POR_DOM = 1'b0,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic puc_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic wr_i,
  input  logic wd_i,
  output logic q_o
);
  generate
    if (IMPL) begin : g_impl
      logic q_r;
      always_ff @(posedge clk_i) begin
        if (por_i || (puc_i && !POR_DOM)) q_r <= RST_VAL;
        else if (set_i)                   q_r <= 1'b1;
        else if (clr_i)                   q_r <= 1'b0;
        else if (wr_i)                    q_r <= wd_i;
      end
      assign q_o = q_r;
    end else begin : g_absent
      logic unused_in;
      assign unused_in = ^{clk_i, por_i, puc_i, set_i, clr_i, wr_i, wd_i};
      assign q_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/sfr_byte_reg.sv
module sfr_byte_reg #(
  parameter int              W        = 8,
  parameter logic [W-1:0]    IMPL_MSK = '1,
  parameter logic [W-1:0]    POR_MSK  = '0,
  parameter logic [W-1:0]    RST_VAL  = '0
) (
  input  logic         clk_i,
  input  logic         por_i,
  input  logic         puc_i,
  input  logic         wr_i,
  input  logic [W-1:0] wd_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    sfr_bit_cell #(
      .IMPL   (IMPL_MSK[b]),
      .POR_DOM(POR_MSK[b]),
      .RST_VAL(RST_VAL[b])
    ) u_cell (
      .clk_i(clk_i),
      .por_i(por_i),
      .puc_i(puc_i),
      .set_i(set_i[b]),
      .clr_i(clr_i[b]),
      .wr_i (wr_i),
      .wd_i (wd_i[b]),
      .q_o  (q_o[b])
    );
  end
endmodule

// File: rtl/sfr_read_port.sv
module sfr_read_port #(
  parameter int W    = 8,
  parameter int AW   = 2,
  parameter int NREG = 4
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            rd_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [NREG*W-1:0] regs_i,
  output logic [W-1:0]    rdata_o
);
  logic [W-1:0] sel_word;

  always_comb begin
    sel_word = '0;
    for (int k = 0; k < NREG; k++)
      if (addr_i == AW'(k)) sel_word = regs_i[k*W +: W];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)     rdata_o <= '0;
    else if (rd_i) rdata_o <= sel_word;
  end
endmodule

// File: rtl/sfr_bank.sv
module sfr_bank
  import sfr_pkg::*;
#(
  parameter int N_CH = 2
) (
  input  logic              clk_i,
  input  logic              por_i,
  input  logic              puc_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [SFR_AW-1:0] bus_addr_i,
  input  logic [SFR_DW-1:0] bus_wdata_i,
  output logic [SFR_DW-1:0] bus_rdata_o,
  input  logic              wdt_evt_i,
  input  logic              pin_rst_evt_i,
  input  logic              osc_fault_evt_i,
  input  logic              nmi_evt_i,
  input  logic [N_CH-1:0]   ser_rx_evt_i,
  input  logic [N_CH-1:0]   ser_tx_evt_i,
  input  logic              interval_mode_i,
  output logic [SFR_DW-1:0] ie1_o,
  output logic [SFR_DW-1:0] ie2_o,
  output logic [SFR_DW-1:0] ifg1_o,
  output logic [SFR_DW-1:0] ifg2_o,
  output logic              wdt_irq_en_o
);
  localparam logic [SFR_DW-1:0] SER_IMPL = ser_mask(N_CH);
  localparam logic [SFR_DW-1:0] SER_RSTV = ser_tx_mask(N_CH);

  logic wr_ok, rd_req;
  logic [SFR_NREG-1:0] wr_en;
  logic [SFR_DW-1:0] ifg1_set, ifg1_clr, ifg2_set;

  assign wr_ok  = bus_sel_i && bus_wr_i && !puc_i && !por_i;
  assign rd_req = bus_sel_i && !bus_wr_i;

  always_comb begin
    for (int k = 0; k < SFR_NREG; k++)
      wr_en[k] = wr_ok && (bus_addr_i == SFR_AW'(k));
  end

  // Hardware set and clear vectors; a set in a cell outranks its clear and a write
  always_comb begin
    ifg1_set        = '0;
    ifg1_set[B_WDT] = wdt_evt_i;
    ifg1_set[B_OSC] = osc_fault_evt_i;
    ifg1_set[B_RST] = pin_rst_evt_i;
    ifg1_set[B_NMI] = nmi_evt_i;
    ifg1_clr        = '0;
    ifg1_clr[B_WDT] = pin_rst_evt_i;
    ifg2_set        = '0;
    for (int c = 0; c < N_CH; c++) begin
      ifg2_set[2*c]   = ser_rx_evt_i[c];
      ifg2_set[2*c+1] = ser_tx_evt_i[c];
    end
  end

  sfr_byte_reg #(.W(SFR_DW), .IMPL_MSK(IE1_IMPL), .POR_MSK('0), .RST_VAL('0)) u_ie1 (
    .clk_i(clk_i), .por_i(por_i), .puc_i(puc_i),
    .wr_i(wr_en[A_IE1]), .wd_i(bus_wdata_i),
    .set_i('0), .clr_i('0), .q_o(ie1_o)
  );

  sfr_byte_reg #(.W(SFR_DW), .IMPL_MSK(SER_IMPL), .POR_MSK('0), .RST_VAL('0)) u_ie2 (
    .clk_i(clk_i), .por_i(por_i), .puc_i(puc_i),
    .wr_i(wr_en[A_IE2]), .wd_i(bus_wdata_i),
    .set_i('0), .clr_i('0), .q_o(ie2_o)
  );

  sfr_byte_reg #(.W(SFR_DW), .IMPL_MSK(IFG1_IMPL), .POR_MSK(IFG1_PORD), .RST_VAL(IFG1_RSTV)) u_ifg1 (
    .clk_i(clk_i), .por_i(por_i), .puc_i(puc_i),
    .wr_i(wr_en[A_IFG1]), .wd_i(bus_wdata_i),
    .set_i(ifg1_set), .clr_i(ifg1_clr), .q_o(ifg1_o)
  );

  sfr_byte_reg #(.W(SFR_DW), .IMPL_MSK(SER_IMPL), .POR_MSK('0), .RST_VAL(SER_RSTV)) u_ifg2 (
    .clk_i(clk_i), .por_i(por_i), .puc_i(puc_i),
    .wr_i(wr_en[A_IFG2]), .wd_i(bus_wdata_i),
    .set_i(ifg2_set), .clr_i('0), .q_o(ifg2_o)
  );

  sfr_read_port #(.W(SFR_DW), .AW(SFR_AW), .NREG(SFR_NREG)) u_rd (
    .clk_i(clk_i),
    .rst_i(por_i || puc_i),
    .rd_i(rd_req),
    .addr_i(bus_addr_i),
    .regs_i({ifg2_o, ifg1_o, ie2_o, ie1_o}),
    .rdata_o(bus_rdata_o)
  );

  // Watchdog enable only reaches the interrupt path in interval-timer mode
  always_ff @(posedge clk_i) begin
    if (por_i || puc_i) wdt_irq_en_o <= 1'b0;
    else                wdt_irq_en_o <= ie1_o[B_WDT] && interval_mode_i;
  end
endmodule

// File: rtl/sfr_bank_chk.sv
module sfr_bank_chk (
  input logic       clk_i,
  input logic       por_i,
  input logic       puc_i,
  input logic       bus_sel_i,
  input logic       bus_wr_i,
  input logic [1:0] bus_addr_i,
  input logic [7:0] bus_rdata_o,
  input logic       wdt_evt_i,
  input logic       pin_rst_evt_i,
  input logic       osc_fault_evt_i,
  input logic       interval_mode_i,
  input logic [7:0] ie1_o,
  input logic [7:0] ie2_o,
  input logic [7:0] ifg1_o,
  input logic       wdt_irq_en_o
);
  AST_POR_STATE: assert property (@(posedge clk_i) disable iff (por_i)
    $fell(por_i) |-> (ifg1_o == 8'h06 && ie1_o == 8'h00 && ie2_o == 8'h00)); // R1

  AST_PUC_KEEPS_CAUSE: assert property (@(posedge clk_i) disable iff (por_i)
    (puc_i && !pin_rst_evt_i && !wdt_evt_i) |=>
      (ifg1_o[3:2] == $past(ifg1_o[3:2]) && ifg1_o[0] == $past(ifg1_o[0]))); // R2

  AST_PIN_RST_FLAGS: assert property (@(posedge clk_i) disable iff (por_i)
    (pin_rst_evt_i && !wdt_evt_i) |=> (ifg1_o[3] && !ifg1_o[0])); // R3

  AST_OSC_SET_WINS: assert property (@(posedge clk_i) disable iff (por_i)
    osc_fault_evt_i |=> ifg1_o[1]); // R5

  AST_UNIMPL_ZERO: assert property (@(posedge clk_i) disable iff (por_i)
    (bus_sel_i && !bus_wr_i && bus_addr_i == 2'd0 && !puc_i) |=>
      ((bus_rdata_o & 8'hCC) == 8'h00)); // R6

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (por_i)
    (!(bus_sel_i && !bus_wr_i) && !puc_i) |=> $stable(bus_rdata_o)); // R7

  AST_WDT_MODE_GATE: assert property (@(posedge clk_i) disable iff (por_i)
    !interval_mode_i |=> !wdt_irq_en_o); // R8
endmodule

bind sfr_bank sfr_bank_chk u_chk (
  .clk_i(clk_i), .por_i(por_i), .puc_i(puc_i),
  .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
  .bus_rdata_o(bus_rdata_o), .wdt_evt_i(wdt_evt_i),
  .pin_rst_evt_i(pin_rst_evt_i), .osc_fault_evt_i(osc_fault_evt_i),
  .interval_mode_i(interval_mode_i), .ie1_o(ie1_o), .ie2_o(ie2_o),
  .ifg1_o(ifg1_o), .wdt_irq_en_o(wdt_irq_en_o)
);

// File: tb/sfr_bank_test.sv
module sfr_bank_test;
  logic       clk = 1'b0;
  logic       por = 1'b1, puc = 1'b1;
  logic       sel = 1'b0, wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       wdt_evt = 0, pin_evt = 0, osc_evt = 0, nmi_evt = 0;
  logic [1:0] rx_evt = '0, tx_evt = '0;
  logic       ivl = 1'b0;
  logic [7:0] ie1, ie2, ifg1, ifg2;
  logic       wdt_ie;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  sfr_bank #(.N_CH(2)) uut (
    .clk_i(clk), .por_i(por), .puc_i(puc),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .wdt_evt_i(wdt_evt), .pin_rst_evt_i(pin_evt),
    .osc_fault_evt_i(osc_evt), .nmi_evt_i(nmi_evt),
    .ser_rx_evt_i(rx_evt), .ser_tx_evt_i(tx_evt),
    .interval_mode_i(ivl),
    .ie1_o(ie1), .ie2_o(ie2), .ifg1_o(ifg1), .ifg2_o(ifg2),
    .wdt_irq_en_o(wdt_ie)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); sel = 1; wr = 0; addr = a;
    @(negedge clk); sel = 0;
    v = rdata;
  endtask

  task automatic t_reset_state;
    logic [7:0] v;
    check("R1 ie1 port", ie1, 8'h00);
    check("R1 ifg2 port", ifg2, 8'h0A);
    bus_read(2'd0, v); check("R1 ie1", v, 8'h00);
    bus_read(2'd1, v); check("R1 ie2", v, 8'h00);
    bus_read(2'd2, v); check("R1 ifg1", v, 8'h06);
    bus_read(2'd3, v); check("R1 ifg2", v, 8'h0A);
  endtask

  task automatic t_masks;
    logic [7:0] v;
    bus_write(2'd0, 8'hFF); bus_read(2'd0, v); check("R6 ie1 mask", v, 8'h33);
    bus_write(2'd1, 8'hFF); bus_read(2'd1, v); check("R6 ie2 mask", v, 8'h0F);
    bus_write(2'd2, 8'h00); bus_read(2'd2, v); check("R6 ifg1 clear", v, 8'h00);
    bus_write(2'd2, 8'hFF); bus_read(2'd2, v); check("R6 ifg1 mask", v, 8'h1F);
    bus_write(2'd3, 8'h00); bus_read(2'd3, v); check("R6 ifg2 clear", v, 8'h00);
    bus_write(2'd3, 8'hFF); bus_read(2'd3, v); check("R6 ifg2 mask", v, 8'h0F);
  endtask

  task automatic t_read_hold;
    bus_write(2'd0, 8'h00);
    check("R7 rdata holds across write", rdata, 8'h0F);
    repeat (2) @(negedge clk);
    check("R7 rdata holds idle", rdata, 8'h0F);
  endtask

  task automatic t_puc;
    logic [7:0] v;
    bus_write(2'd0, 8'h33); bus_write(2'd1, 8'h0F);
    bus_write(2'd2, 8'h1F); bus_write(2'd3, 8'h00);
    @(negedge clk); puc = 1;
    repeat (2) @(negedge clk); puc = 0;
    check("R2 ie1", ie1, 8'h00);
    check("R2 ie2", ie2, 8'h00);
    check("R2 ifg1 causes kept", ifg1, 8'h0F);
    bus_read(2'd3, v); check("R2 ifg2", v, 8'h0A);
  endtask

  task automatic t_pin_reset;
    bus_write(2'd2, 8'h01);
    @(negedge clk); puc = 1; pin_evt = 1;
    @(negedge clk); puc = 0; pin_evt = 0;
    check("R3 pin reset sets rst clears wdt", ifg1, 8'h0A);
    bus_write(2'd2, 8'h00);
    @(negedge clk); pin_evt = 1; wdt_evt = 1;
    @(negedge clk); pin_evt = 0; wdt_evt = 0;
    check("R3 pin reset with watchdog", ifg1, 8'h09);
  endtask

  task automatic t_events;
    bus_write(2'd2, 8'h00); bus_write(2'd3, 8'h00);
    @(negedge clk); wdt_evt = 1; @(negedge clk); wdt_evt = 0;
    check("R4 watchdog flag", ifg1, 8'h01);
    @(negedge clk); osc_evt = 1; @(negedge clk); osc_evt = 0;
    check("R4 osc flag", ifg1, 8'h03);
    @(negedge clk); nmi_evt = 1; @(negedge clk); nmi_evt = 0;
    check("R4 nmi flag", ifg1, 8'h13);
    @(negedge clk); rx_evt = 2'b01; @(negedge clk); rx_evt = 0;
    check("R4 rx ch0", ifg2, 8'h01);
    @(negedge clk); tx_evt = 2'b10; @(negedge clk); tx_evt = 0;
    check("R4 tx ch1", ifg2, 8'h09);
  endtask

  task automatic t_set_beats_write;
    @(negedge clk); sel = 1; wr = 1; addr = 2'd2; wdata = 8'h00; osc_evt = 1;
    @(negedge clk); sel = 0; wr = 0; osc_evt = 0;
    check("R5 osc set beats clear", ifg1, 8'h02);
    @(negedge clk); sel = 1; wr = 1; addr = 2'd3; wdata = 8'h00; rx_evt = 2'b10;
    @(negedge clk); sel = 0; wr = 0; rx_evt = 0;
    check("R5 rx set beats clear", ifg2, 8'h04);
  endtask

  task automatic t_wdt_mode;
    bus_write(2'd0, 8'h01);
    @(negedge clk); ivl = 0; @(negedge clk);
    check("R8 watchdog mode gates", {7'd0, wdt_ie}, 8'h00);
    ivl = 1; @(negedge clk);
    check("R8 interval mode passes", {7'd0, wdt_ie}, 8'h01);
    bus_write(2'd0, 8'h00); @(negedge clk);
    check("R8 enable cleared", {7'd0, wdt_ie}, 8'h00);
    ivl = 0;
  endtask

  task automatic t_write_in_reset;
    logic [7:0] v;
    @(negedge clk); puc = 1;
    bus_write(2'd0, 8'hFF);
    bus_write(2'd3, 8'h00);
    @(negedge clk); puc = 0;
    bus_read(2'd0, v); check("R9 write during clear dropped ie1", v, 8'h00);
    bus_read(2'd3, v); check("R9 write during clear dropped ifg2", v, 8'h0A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por = 0; puc = 0;
    t_reset_state();
    t_masks();
    t_read_hold();
    t_puc();
    t_pin_reset();
    t_events();
    t_set_beats_write();
    t_wdt_mode();
    t_write_in_reset();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule